// File: doc/BRIEF.md
# DMA Channel Register Bank

This block holds the programming state of a multi-channel DMA controller. Software reaches it through a simple word-wide bus. Each channel has a 16-byte window holding four registers: source address, destination address, a first control word and a second control word. A small global area holds the interrupt unmask bits, the sticky per-channel done bits and a configuration word. The configuration word carries an arbitration select and two read-only identity fields.

The per-channel registers are presented on flat output vectors, one slice per channel, to the engines that move the data. Software writes the first control word last. When that write sets the enable bit, the bank sends a one-cycle start pulse to that channel's engine. When the engine finishes, it returns a one-cycle done pulse. The done pulse drops the channel's enable bit, so software can poll for an idle channel. If the channel had asked for an interrupt, the pulse also latches a sticky done bit. Software clears done bits by writing ones to them. The interrupt line is high while any done bit is set and its unmask bit is also set.

Top module: `dma_regbank`

## Requirements
- R1: After reset, every channel register, the unmask register and the done register read 0, and `irq` and `ch_start` are 0.
- R2: The registers of channel n are at byte offsets n*0x10 plus 0x0 (source), 0x4 (destination), 0x8 (control word A) and 0xC (control word B). The source and destination registers store and return all 32 bits.
- R3: Control word A keeps bits 31:16 (length), 7 (source fixed), 6 (destination fixed), 5:3 (burst code), 2 (done-interrupt enable), 1 (enable) and 0 (memory-to-memory mode), and reads 0 in bits 15:8. Control word B keeps bits 25:22, 21:16, 13:8, 7:3, 2, 1 and 0, and reads 0 in all other bits. Both words appear unchanged on the channel's configuration outputs.
- R4: A write to control word A with bit 1 set raises that channel's `ch_start` bit for exactly the one cycle after the write, and no other channel's bit.
- R5: A done pulse on a channel clears bit 1 of its control word A and leaves its other bits unchanged.
- R6: A done pulse sets the channel's bit in the done register (byte address 0x204, bit n for channel n) only when bit 2 of its control word A is set.
- R7: Writing to the done register clears each bit written as 1 and leaves bits written as 0 unchanged. A done pulse arriving in the same cycle as a clear of the same bit leaves the bit set.
- R8: `irq` is high exactly while some bit is set both in the done register and in the unmask register (byte address 0x220-0x20 = 0x200, bit n for channel n).
- R9: The configuration register at byte address 0x220 holds a writable round-robin select in bit 0, also driven on `arb_round_robin`. Bits 2:1 read the revision parameter and bits 4:3 read c, where the channel count is 8 shifted left by c. All other bits read 0.
- R10: Writing 0 to control word A returns it to its reset value and produces no start pulse.
- R11: Addresses outside the channel windows and the three global registers read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, valid in the same cycle |
| cfg_src | output | NUM_CH*32 | Source address of each channel |
| cfg_dst | output | NUM_CH*32 | Destination address of each channel |
| cfg_ctrl_a | output | NUM_CH*32 | Control word A of each channel |
| cfg_ctrl_b | output | NUM_CH*32 | Control word B of each channel |
| ch_start | output | NUM_CH | One-cycle start pulse per channel |
| ch_done | input | NUM_CH | One-cycle completion pulse per channel |
| arb_round_robin | output | 1 | Round-robin arbitration select |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the bank with its defaults: sixteen channels, a 10-bit address and revision 1. With these values the channel-count code reads 1 and the configuration word reads 0x0A after reset. The sixteen-channel size reaches both the lowest and the highest channel window. It also leaves the gap from 0x100 to 0x1FF unmapped, so the bench can check that writes there are ignored. The bench also drives a done pulse in the same cycle as a software clear of the same bit, to check that the pulse wins.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    // word slot inside a channel window (byte address bits 3:2)
    localparam logic [1:0] SLOT_SRC  = 2'd0;
    localparam logic [1:0] SLOT_DST  = 2'd1;
    localparam logic [1:0] SLOT_CA   = 2'd2;
    localparam logic [1:0] SLOT_CB   = 2'd3;

    // global registers, byte addresses
    localparam int unsigned UNMASK_ADDR = 32'h200;
    localparam int unsigned DONE_ADDR   = 32'h204;
    localparam int unsigned GCFG_ADDR   = 32'h220;

    localparam logic [31:0] CA_KEEP = 32'hFFFF_00FF;
    localparam logic [31:0] CB_KEEP = 32'h03FF_3FFF;

    typedef struct packed {
        logic [15:0] length;
        logic [7:0]  rsvd;
        logic        src_fixed;
        logic        dst_fixed;
        logic [2:0]  burst;
        logic        irq_en;
        logic        enable;
        logic        mem2mem;
    } ctrl_a_t;

    typedef struct packed {
        logic [5:0]  rsvd_hi;
        logic [3:0]  segment;
        logic [5:0]  src_req;
        logic [1:0]  rsvd_mid;
        logic [5:0]  dst_req;
        logic [4:0]  chain_to;
        logic        coherent;
        logic        fail;
        logic        mask;
    } ctrl_b_t;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        ctrl_a_t     ca;
        ctrl_b_t     cb;
    } chan_regs_t;

    function automatic logic [1:0] count_code(input int unsigned nch);
        return 2'($clog2(nch / 8));
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_slot,
    input  logic [31:0] wr_data,
    input  logic        done_in,
    output chan_regs_t  regs,
    output logic        start,
    output logic        done_event
);
    logic ca_write;

    assign ca_write   = wr_en && (wr_slot == SLOT_CA);
    assign done_event = done_in && regs.ca.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs  <= '0;
            start <= 1'b0;
        end else begin
            start <= ca_write && wr_data[1];
            if (wr_en) begin
                case (wr_slot)
                    SLOT_SRC: regs.src <= wr_data;
                    SLOT_DST: regs.dst <= wr_data;
                    SLOT_CA:  regs.ca  <= ctrl_a_t'(wr_data & CA_KEEP);
                    default:  regs.cb  <= ctrl_b_t'(wr_data & CB_KEEP);
                endcase
            end
            if (done_in && !ca_write)
                regs.ca.enable <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_done_status.sv
module dma_done_status #(
    parameter int unsigned NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] set_vec,
    input  logic              clr_wr,
    input  logic [NUM_CH-1:0] clr_bits,
    input  logic              unmask_wr,
    input  logic [NUM_CH-1:0] unmask_data,
    output logic [NUM_CH-1:0] status,
    output logic [NUM_CH-1:0] unmask,
    output logic              irq
);
    logic [NUM_CH-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            unmask <= '0;
        end else begin
            status <= (status & ~clr_eff) | set_vec;
            if (unmask_wr)
                unmask <= unmask_data;
        end
    end

    assign irq = |(status & unmask);
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
    import dma_regs_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned ADDR_W = 10,
    parameter logic [1:0]  REV    = 2'd1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_en,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_CH*32-1:0] cfg_src,
    output logic [NUM_CH*32-1:0] cfg_dst,
    output logic [NUM_CH*32-1:0] cfg_ctrl_a,
    output logic [NUM_CH*32-1:0] cfg_ctrl_b,
    output logic [NUM_CH-1:0]    ch_start,
    input  logic [NUM_CH-1:0]    ch_done,
    output logic                 arb_round_robin,
    output logic                 irq
);
    localparam int unsigned IDX_W    = $clog2(NUM_CH);
    localparam int unsigned WIN_END  = NUM_CH * 16;
    localparam int unsigned WA_W     = ADDR_W - 2;
    localparam logic [1:0]  CNT_CODE = count_code(NUM_CH);

    logic [WA_W-1:0]   waddr;
    logic              in_win;
    logic [IDX_W-1:0]  ch_idx;
    logic [1:0]        slot;
    logic              wr;
    logic              unmask_hit, done_hit, gcfg_hit;
    chan_regs_t        regs [NUM_CH];
    logic [NUM_CH-1:0] done_set;
    logic [NUM_CH-1:0] done_status;
    logic [NUM_CH-1:0] unmask_bits;
    logic              rr_sel;

    assign waddr      = bus_addr[ADDR_W-1:2];
    assign in_win     = 32'(bus_addr) < WIN_END;
    assign ch_idx     = bus_addr[4 +: IDX_W];
    assign slot       = bus_addr[3:2];
    assign wr         = bus_en && bus_wr;
    assign unmask_hit = 32'(waddr) == UNMASK_ADDR / 4;
    assign done_hit   = 32'(waddr) == DONE_ADDR / 4;
    assign gcfg_hit   = 32'(waddr) == GCFG_ADDR / 4;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        logic sel_wr;
        assign sel_wr = wr && in_win && (ch_idx == IDX_W'(i));

        dma_chan_regs u_chan (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (sel_wr),
            .wr_slot    (slot),
            .wr_data    (bus_wdata),
            .done_in    (ch_done[i]),
            .regs       (regs[i]),
            .start      (ch_start[i]),
            .done_event (done_set[i])
        );

        assign cfg_src[i*32 +: 32]    = regs[i].src;
        assign cfg_dst[i*32 +: 32]    = regs[i].dst;
        assign cfg_ctrl_a[i*32 +: 32] = regs[i].ca;
        assign cfg_ctrl_b[i*32 +: 32] = regs[i].cb;
    end

    dma_done_status #(.NUM_CH(NUM_CH)) u_status (
        .clk         (clk),
        .rst         (rst),
        .set_vec     (done_set),
        .clr_wr      (wr && done_hit),
        .clr_bits    (bus_wdata[NUM_CH-1:0]),
        .unmask_wr   (wr && unmask_hit),
        .unmask_data (bus_wdata[NUM_CH-1:0]),
        .status      (done_status),
        .unmask      (unmask_bits),
        .irq         (irq)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rr_sel <= 1'b0;
        else if (wr && gcfg_hit)
            rr_sel <= bus_wdata[0];
    end

    assign arb_round_robin = rr_sel;

    always_comb begin
        bus_rdata = '0;
        if (in_win) begin
            case (slot)
                SLOT_SRC: bus_rdata = regs[ch_idx].src;
                SLOT_DST: bus_rdata = regs[ch_idx].dst;
                SLOT_CA:  bus_rdata = regs[ch_idx].ca;
                default:  bus_rdata = regs[ch_idx].cb;
            endcase
        end else if (unmask_hit) begin
            bus_rdata = 32'(unmask_bits);
        end else if (done_hit) begin
            bus_rdata = 32'(done_status);
        end else if (gcfg_hit) begin
            bus_rdata = {27'd0, CNT_CODE, REV, rr_sel};
        end
    end
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned ADDR_W = 10,
    parameter logic [1:0]  REV    = 2'd1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_en,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic [NUM_CH-1:0]    ch_start,
    input logic [NUM_CH-1:0]    ch_done,
    input logic [NUM_CH*32-1:0] cfg_ctrl_a,
    input logic                 irq,
    input logic [NUM_CH-1:0]    status,
    input logic [NUM_CH-1:0]    unmask
);
    localparam logic [1:0] CODE = 2'($clog2(NUM_CH / 8));

    logic ca_wr_any;
    assign ca_wr_any = bus_en && bus_wr && bus_addr[3:2] == 2'd2
                       && 32'(bus_addr) < NUM_CH * 16;

    a_r4_start_from_write: assert property (@(posedge clk) disable iff (rst)
        (|ch_start) |-> $past(ca_wr_any && bus_wdata[1]))
        else $error("R4: start pulse without an enabling write");

    a_r8_irq_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past((|ch_done) || (bus_en && bus_wr && 32'(bus_addr[ADDR_W-1:2]) == 32'h80)))
        else $error("R8: irq rose without a done pulse or unmask write");

    a_r9_gcfg_const: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_wr && 32'(bus_addr[ADDR_W-1:2]) == 32'h88)
        |-> (bus_rdata[4:1] == {CODE, REV} && bus_rdata[31:5] == 27'd0))
        else $error("R9: configuration word constants wrong");

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic ca_wr_i, clr_i;
        assign ca_wr_i = ca_wr_any && 32'(bus_addr[ADDR_W-1:4]) == i;
        assign clr_i   = bus_en && bus_wr && 32'(bus_addr[ADDR_W-1:2]) == 32'h81
                         && bus_wdata[i];

        a_r5_done_drops_enable: assert property (@(posedge clk) disable iff (rst)
            (ch_done[i] && !ca_wr_i) |=> !cfg_ctrl_a[i*32 + 1])
            else $error("R5: enable survived a done pulse");

        a_r6_no_set_without_ie: assert property (@(posedge clk) disable iff (rst)
            (!status[i] && !(ch_done[i] && cfg_ctrl_a[i*32 + 2])) |=> !status[i])
            else $error("R6: done bit set without interrupt enable");

        a_r7_w1c_clears: assert property (@(posedge clk) disable iff (rst)
            (clr_i && !ch_done[i]) |=> !status[i])
            else $error("R7: write-one did not clear the done bit");
    end

    a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (unmask == '0) |-> !irq)
        else $error("R8: irq high with every channel masked");
endmodule

bind dma_regbank dma_regbank_chk #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .REV(REV)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_en     (bus_en),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ch_start   (ch_start),
    .ch_done    (ch_done),
    .cfg_ctrl_a (cfg_ctrl_a),
    .irq        (irq),
    .status     (done_status),
    .unmask     (unmask_bits)
);

// File: tb/dma_regbank_tb_top.sv
module dma_regbank_tb_top;
    localparam int unsigned NUM_CH = 16;
    localparam int unsigned ADDR_W = 10;
    localparam time         CLK_PERIOD = 10ns;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 bus_en = 1'b0;
    logic                 bus_wr = 1'b0;
    logic [ADDR_W-1:0]    bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic [NUM_CH*32-1:0] cfg_src, cfg_dst, cfg_ctrl_a, cfg_ctrl_b;
    logic [NUM_CH-1:0]    ch_start;
    logic [NUM_CH-1:0]    ch_done = '0;
    logic                 arb_round_robin;
    logic                 irq;

    int       n_checks = 0;
    int       n_fail = 0;
    bit       finished = 1'b0;
    rd_item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_regbank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .REV(2'd1)) dut_i (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_ctrl_a(cfg_ctrl_a),
        .cfg_ctrl_b(cfg_ctrl_b), .ch_start(ch_start), .ch_done(ch_done),
        .arb_round_robin(arb_round_robin), .irq(irq)
    );

    // monitor: compares each read against the scoreboard head
    always @(negedge clk) begin
        if (bus_en && !bus_wr) begin
            if (sb_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL scoreboard: read at %h with no expected item", bus_addr);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (bus_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: addr %h actual %h expected %h",
                             it.tag, bus_addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input int unsigned a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int unsigned a, input logic [31:0] exp, input string tag);
        rd_item_t it;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = ADDR_W'(a);
        @(posedge clk); #1;
        bus_en = 1'b0;
    endtask

    task automatic pulse_done(input logic [NUM_CH-1:0] m);
        @(posedge clk); #1;
        ch_done = m;
        @(posedge clk); #1;
        ch_done = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        check("R1 irq after reset", 32'(irq), 32'd0);
        check("R1 ch_start after reset", 32'(ch_start), 32'd0);
        bus_read(32'h000, 32'h0, "R1 ch0 source");
        bus_read(32'h0F8, 32'h0, "R1 ch15 control A");
        bus_read(32'h200, 32'h0, "R1 unmask");
        bus_read(32'h204, 32'h0, "R1 done");
        bus_read(32'h220, 32'h0000_000A, "R9 config after reset");

        // R2 address map
        bus_write(32'h030, 32'hDEAD_BEEF);
        bus_write(32'h034, 32'h1234_5678);
        bus_write(32'h0F0, 32'hA5A5_5A5A);
        bus_read(32'h030, 32'hDEAD_BEEF, "R2 ch3 source");
        bus_read(32'h034, 32'h1234_5678, "R2 ch3 destination");
        bus_read(32'h0F0, 32'hA5A5_5A5A, "R2 ch15 source");
        bus_read(32'h020, 32'h0, "R2 ch2 source untouched");
        check("R2 ch3 source output", cfg_src[3*32 +: 32], 32'hDEAD_BEEF);

        // R3 field layout
        bus_write(32'h03C, 32'hFFFF_FFFF);
        bus_write(32'h038, 32'hFFFF_FFFD);
        bus_read(32'h03C, 32'h03FF_3FFF, "R3 control B kept bits");
        bus_read(32'h038, 32'hFFFF_00FD, "R3 control A kept bits");
        check("R3 control A output", cfg_ctrl_a[3*32 +: 32], 32'hFFFF_00FD);
        check("R3 control B output", cfg_ctrl_b[3*32 +: 32], 32'h03FF_3FFF);

        // R4 start pulse
        bus_write(32'h058, 32'h0040_0006);
        @(negedge clk);
        check("R4 start during cycle after write", 32'(ch_start), 32'h0000_0020);
        @(negedge clk);
        check("R4 start lasts one cycle", 32'(ch_start), 32'd0);
        bus_read(32'h058, 32'h0040_0006, "R4 control A enabled");

        // R5/R6 completion with interrupt enable
        pulse_done(16'h0020);
        bus_read(32'h058, 32'h0040_0004, "R5 enable cleared by done");
        bus_read(32'h204, 32'h0000_0020, "R6 done bit set with irq_en");
        check("R8 irq masked", 32'(irq), 32'd0);

        // R8 unmask
        bus_write(32'h200, 32'h0000_0020);
        check("R8 irq unmasked", 32'(irq), 32'd1);
        bus_write(32'h200, 32'h0000_0010);
        check("R8 irq other channel unmasked", 32'(irq), 32'd0);
        bus_write(32'h200, 32'h0000_0020);

        // R7 write-one-to-clear
        bus_write(32'h204, 32'h0000_0000);
        bus_read(32'h204, 32'h0000_0020, "R7 zero write keeps bit");
        bus_write(32'h204, 32'h0000_0020);
        bus_read(32'h204, 32'h0, "R7 one write clears bit");
        check("R8 irq after clear", 32'(irq), 32'd0);

        // R6 negative: no interrupt enable
        bus_write(32'h068, 32'h0000_0002);
        pulse_done(16'h0040);
        bus_read(32'h068, 32'h0, "R5 ch6 enable cleared");
        bus_read(32'h204, 32'h0, "R6 no done bit without irq_en");

        // R7 set wins over same-cycle clear
        bus_write(32'h058, 32'h0000_0006);
        @(posedge clk); #1;
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = ADDR_W'(32'h204); bus_wdata = 32'h20;
        ch_done = 16'h0020;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_wr = 1'b0; ch_done = '0;
        bus_read(32'h204, 32'h0000_0020, "R7 set wins over clear");
        check("R8 irq after collision", 32'(irq), 32'd1);
        bus_write(32'h204, 32'h0000_FFFF);
        check("R8 irq after full clear", 32'(irq), 32'd0);

        // R10 zero write aborts
        bus_write(32'h078, 32'h0010_0006);
        bus_write(32'h078, 32'h0000_0000);
        @(negedge clk);
        check("R10 no start on zero write", 32'(ch_start), 32'd0);
        bus_read(32'h078, 32'h0, "R10 control A back to reset");

        // R9 configuration word
        bus_write(32'h220, 32'hFFFF_FFFF);
        bus_read(32'h220, 32'h0000_000B, "R9 only select bit writable");
        check("R9 round-robin output", 32'(arb_round_robin), 32'd1);

        // R11 unmapped space
        bus_write(32'h100, 32'hFFFF_FFFF);
        bus_write(32'h3FC, 32'hFFFF_FFFF);
        bus_read(32'h100, 32'h0, "R11 unmapped read");
        bus_read(32'h000, 32'h0, "R11 ch0 source unchanged");
        bus_read(32'h208, 32'h0, "R11 gap after done register");
        bus_read(32'h200, 32'h0000_0020, "R11 unmask unchanged");

        @(posedge clk);
        check("scoreboard drained", 32'(sb_q.size()), 32'd0);
        finish_run();
    end
endmodule